// File: doc/BRIEF.md
# Burst-Splitting Read Master Bridge

This block lets a simple client read large regions of memory over an AXI4 read port. The client hands over a byte start address, a word count and a valid. The bridge queues the request and cuts it into INCR bursts that fit the AXI4 length limit. It issues those bursts on the read address channel and passes the returned beats back as a plain valid-qualified stream.

Several requests may be in flight at once, up to a fixed limit. A single ready output tells the client when it can present another request. All traffic uses one AXI ID, so beats and completions come back in request order. The client may apply backpressure through a data-ready input. When that input is not used, the bridge treats it as always high.

Top module: `rdb_bridge`

## Requirements
- R1: After reset, `req_ready_o` is 1, `ar_valid_o` is 0 and `rsp_valid_o` is 0.
- R2: A request with nonzero length stays outstanding from the clock edge that accepts it until its completion pulse. With MAX_OUT (4) outstanding, `req_ready_o` is 0, and no further request is taken. In the cycle after a completion, `req_ready_o` is 1 again.
- R3: The address and length are captured at the accepting edge. Input changes after that edge do not alter the bursts issued for that request.
- R4: A request of L words starting at byte address A is issued as ceil(L/256) bursts in order. Burst k starts at A + k*1024 and has `ar_len_o` equal to min(256, L-256k) - 1. The address step assumes a 4-byte word.
- R5: Every burst carries `ar_burst_o` = 2'b01 (INCR) and `ar_size_o` = log2(bytes per word), which is 3'd2 for 32-bit data.
- R6: Once `ar_valid_o` is high, it stays high and the address and length stay stable until `ar_ready_i` is seen high.
- R7: Each R beat that is taken appears in the same cycle on `rsp_data_o`/`rsp_resp_o` with `rsp_valid_o` high. `rsp_last_o` is high on the beat that ends each burst.
- R8: `r_ready_o` follows `rsp_dready_i`. While `rsp_dready_i` is 0, no beat is taken and `rsp_valid_o` stays 0.
- R9: `req_done_o` pulses for one cycle on the final beat of the final burst of a request. Pulses come in request order.
- R10: A request of length 0 is accepted and discarded. It issues no burst, produces no completion and does not count as outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_addr_i | input | ADDR_W | Request start byte address |
| req_len_i | input | LEN_W | Request length in words |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Bridge can take a request |
| rsp_data_o | output | DATA_W | Returned data word |
| rsp_resp_o | output | 2 | Read status for the word |
| rsp_valid_o | output | 1 | Returned word valid |
| rsp_last_o | output | 1 | Word ends an AXI burst |
| rsp_dready_i | input | 1 | Client can take data |
| req_done_o | output | 1 | One request fully returned |
| ar_addr_o | output | ADDR_W | AXI read address |
| ar_len_o | output | 8 | AXI burst length minus one |
| ar_size_o | output | 3 | AXI beat size |
| ar_burst_o | output | 2 | AXI burst type |
| ar_valid_o | output | 1 | AXI address valid |
| ar_ready_i | input | 1 | AXI address ready |
| r_data_i | input | DATA_W | AXI read data |
| r_resp_i | input | 2 | AXI read response |
| r_last_i | input | 1 | AXI last beat of burst |
| r_valid_i | input | 1 | AXI read valid |
| r_ready_o | output | 1 | AXI read ready |

## Verification
The hardest state to reach is a full outstanding window with a fifth request waiting, followed by the window reopening on the exact cycle after a completion. The bench holds the memory model's R channel idle while it fills the window. One of the requests has zero length, which checks that it is not counted. The bench then holds a fifth request valid and confirms that no burst appears for it. Finally it releases the R channel and watches for `req_ready_o` one cycle after the first completion pulse.

// File: rtl/rdb_pkg.sv
package rdb_pkg;
  typedef enum logic [1:0] {
    BT_FIXED = 2'b00,
    BT_INCR  = 2'b01,
    BT_WRAP  = 2'b10
  } burst_e;

  localparam int unsigned AXI_MAX_BEATS = 256;
endpackage

// File: rtl/rdb_fifo.sv
module rdb_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= nxt(wp_q);
      if (pop_i)  rp_q <= nxt(rp_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wp_q] <= din_i;
  end

  assign dout_o  = mem_q[rp_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/rdb_splitter.sv
module rdb_splitter #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int DATA_W    = 32,
  parameter int MAX_BURST = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_vld_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  output logic              req_pop_o,
  output logic [ADDR_W-1:0] ar_addr_o,
  output logic [7:0]        ar_len_o,
  output logic [2:0]        ar_size_o,
  output logic [1:0]        ar_burst_o,
  output logic              ar_valid_o,
  input  logic              ar_ready_i
);
  import rdb_pkg::*;

  localparam int SIZE   = $clog2(DATA_W / 8);
  localparam int BEAT_W = $clog2(MAX_BURST) + 1;

  logic              active_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  rem_q;
  logic [BEAT_W-1:0] beats;
  logic              big, ar_hs;

  assign big   = ({1'b0, rem_q} > (LEN_W + 1)'(MAX_BURST));
  assign beats = big ? BEAT_W'(MAX_BURST) : BEAT_W'(rem_q);
  assign ar_hs = active_q && ar_ready_i;

  // one idle cycle between requests keeps the load path shallow
  assign req_pop_o = !active_q && req_vld_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      addr_q   <= '0;
      rem_q    <= '0;
    end else if (req_pop_o) begin
      active_q <= 1'b1;
      addr_q   <= req_addr_i;
      rem_q    <= req_len_i;
    end else if (ar_hs) begin
      addr_q <= addr_q + (ADDR_W'(beats) << SIZE);
      rem_q  <= rem_q - LEN_W'(beats);
      if (!big) active_q <= 1'b0;
    end
  end

  assign ar_valid_o = active_q;
  assign ar_addr_o  = addr_q;
  assign ar_len_o   = 8'(beats - BEAT_W'(1));
  assign ar_size_o  = 3'(SIZE);
  assign ar_burst_o = BT_INCR;
endmodule

// File: rtl/rdb_tracker.sv
module rdb_tracker #(
  parameter int MAX_OUT = 4,
  parameter int NB_W    = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            push_i,
  input  logic [NB_W-1:0] nbursts_i,
  input  logic            last_hs_i,
  output logic            done_o,
  output logic            full_o
);
  logic [NB_W-1:0] head, seen_q;
  logic            empty;

  rdb_fifo #(.W(NB_W), .DEPTH(MAX_OUT)) u_cnt_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push_i),
    .din_i   (nbursts_i),
    .pop_i   (done_o),
    .dout_o  (head),
    .empty_o (empty),
    .full_o  (full_o)
  );

  assign done_o = last_hs_i && !empty && ((seen_q + NB_W'(1)) == head);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        seen_q <= '0;
    else if (done_o)    seen_q <= '0;
    else if (last_hs_i) seen_q <= seen_q + NB_W'(1);
  end
endmodule

// File: rtl/rdb_bridge.sv
module rdb_bridge #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 16,
  parameter int MAX_OUT    = 4,
  parameter int MAX_BURST  = 256,
  parameter bit USE_DREADY = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [1:0]        rsp_resp_o,
  output logic              rsp_valid_o,
  output logic              rsp_last_o,
  input  logic              rsp_dready_i,
  output logic              req_done_o,
  output logic [ADDR_W-1:0] ar_addr_o,
  output logic [7:0]        ar_len_o,
  output logic [2:0]        ar_size_o,
  output logic [1:0]        ar_burst_o,
  output logic              ar_valid_o,
  input  logic              ar_ready_i,
  input  logic [DATA_W-1:0] r_data_i,
  input  logic [1:0]        r_resp_i,
  input  logic              r_last_i,
  input  logic              r_valid_i,
  output logic              r_ready_o
);
  localparam int LOG_B = $clog2(MAX_BURST);
  localparam int NB_W  = LEN_W - LOG_B + 1;
  localparam int RQ_W  = ADDR_W + LEN_W;

  logic              push, rq_empty, rq_full, rq_pop, trk_full, r_hs;
  logic [RQ_W-1:0]   rq_head;
  logic [NB_W-1:0]   nbursts;

  assign req_ready_o = !trk_full && !rq_full;
  assign push        = req_valid_i && req_ready_o && (req_len_i != '0);
  assign nbursts     = NB_W'(({1'b0, req_len_i} + (LEN_W + 1)'(MAX_BURST - 1)) >> LOG_B);

  rdb_fifo #(.W(RQ_W), .DEPTH(MAX_OUT)) u_req_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .din_i   ({req_addr_i, req_len_i}),
    .pop_i   (rq_pop),
    .dout_o  (rq_head),
    .empty_o (rq_empty),
    .full_o  (rq_full)
  );

  rdb_splitter #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .MAX_BURST(MAX_BURST)
  ) u_split (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_vld_i  (!rq_empty),
    .req_addr_i (rq_head[RQ_W-1:LEN_W]),
    .req_len_i  (rq_head[LEN_W-1:0]),
    .req_pop_o  (rq_pop),
    .ar_addr_o  (ar_addr_o),
    .ar_len_o   (ar_len_o),
    .ar_size_o  (ar_size_o),
    .ar_burst_o (ar_burst_o),
    .ar_valid_o (ar_valid_o),
    .ar_ready_i (ar_ready_i)
  );

  generate
    if (USE_DREADY) begin : g_dready
      assign r_ready_o = rsp_dready_i;
    end else begin : g_no_dready
      assign r_ready_o = 1'b1;
    end
  endgenerate

  assign r_hs        = r_valid_i && r_ready_o;
  assign rsp_valid_o = r_hs;
  assign rsp_data_o  = r_data_i;
  assign rsp_resp_o  = r_resp_i;
  assign rsp_last_o  = r_hs && r_last_i;

  rdb_tracker #(.MAX_OUT(MAX_OUT), .NB_W(NB_W)) u_trk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (push),
    .nbursts_i (nbursts),
    .last_hs_i (rsp_last_o),
    .done_o    (req_done_o),
    .full_o    (trk_full)
  );
endmodule

// File: rtl/rdb_bridge_chk.sv
module rdb_bridge_chk #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int MAX_OUT    = 4,
  parameter bit USE_DREADY = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [LEN_W-1:0]  req_len_i,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_last_o,
  input logic              rsp_dready_i,
  input logic              req_done_o,
  input logic [ADDR_W-1:0] ar_addr_o,
  input logic [7:0]        ar_len_o,
  input logic              ar_valid_o,
  input logic              ar_ready_i
);
  localparam int CW = $clog2(MAX_OUT + 1) + 1;
  logic [CW-1:0] cnt_q;
  logic          acc;

  assign acc = req_valid_i && req_ready_o && (req_len_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + CW'(acc) - CW'(req_done_o);
  end

  AST_READY_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == CW'(MAX_OUT)) |-> !req_ready_o); // R2
  AST_READY_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q < CW'(MAX_OUT)) |-> req_ready_o); // R2
  AST_AR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ar_valid_o && !ar_ready_i) |=> (ar_valid_o && $stable(ar_addr_o) && $stable(ar_len_o))); // R6
  AST_AR_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ar_valid_o |-> (cnt_q != '0)); // R10
  AST_DONE_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_done_o |-> (cnt_q != '0)); // R9
  AST_DONE_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_done_o |-> rsp_last_o); // R9
  AST_LAST_IN_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_last_o |-> rsp_valid_o); // R7
  AST_BEAT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_dready_i || !USE_DREADY)); // R8
endmodule

bind rdb_bridge rdb_bridge_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_OUT(MAX_OUT), .USE_DREADY(USE_DREADY)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_len_i    (req_len_i),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_last_o   (rsp_last_o),
  .rsp_dready_i (rsp_dready_i),
  .req_done_o   (req_done_o),
  .ar_addr_o    (ar_addr_o),
  .ar_len_o     (ar_len_o),
  .ar_valid_o   (ar_valid_o),
  .ar_ready_i   (ar_ready_i)
);

// File: tb/rdb_bridge_bench.sv
`timescale 1ns/1ps
module rdb_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] req_addr = '0;
  logic [15:0] req_len = '0;
  logic        req_valid = 1'b0;
  logic        rsp_dready = 1'b1;
  logic        ar_ready = 1'b0;
  logic [31:0] r_data = '0;
  logic [1:0]  r_resp = '0;
  logic        r_last = 1'b0;
  logic        r_valid = 1'b0;

  logic        req_ready_o, rsp_valid_o, rsp_last_o, req_done_o, ar_valid_o, r_ready_o;
  logic [31:0] rsp_data_o, ar_addr_o;
  logic [1:0]  rsp_resp_o, ar_burst_o;
  logic [7:0]  ar_len_o;
  logic [2:0]  ar_size_o;

  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  rdb_bridge u_rdb_bridge (
    .clk_i(clk), .rst_ni(rst_n),
    .req_addr_i(req_addr), .req_len_i(req_len), .req_valid_i(req_valid),
    .req_ready_o(req_ready_o),
    .rsp_data_o(rsp_data_o), .rsp_resp_o(rsp_resp_o), .rsp_valid_o(rsp_valid_o),
    .rsp_last_o(rsp_last_o), .rsp_dready_i(rsp_dready), .req_done_o(req_done_o),
    .ar_addr_o(ar_addr_o), .ar_len_o(ar_len_o), .ar_size_o(ar_size_o),
    .ar_burst_o(ar_burst_o), .ar_valid_o(ar_valid_o), .ar_ready_i(ar_ready),
    .r_data_i(r_data), .r_resp_i(r_resp), .r_last_i(r_last), .r_valid_i(r_valid),
    .r_ready_o(r_ready_o)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // memory model state
  bit          r_en = 1'b0, ar_toggle = 1'b0;
  logic [31:0] log_addr [256];
  logic [7:0]  log_len  [256];
  logic [2:0]  log_size [256];
  logic [1:0]  log_burst[256];
  int          ar_cnt = 0, bq_rd = 0, rb_idx = 0;

  // expected stream state
  logic [31:0] ex_addr [64];
  int          ex_len  [64];
  int          ex_wr = 0, ex_rd = 0, ex_beat = 0, done_cnt = 0;

  initial begin : mem_model
    bit ar_hs, r_hs;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      ar_hs = ar_valid_o && ar_ready;
      r_hs  = r_valid && r_ready_o;
      if (ar_hs) begin
        log_addr[ar_cnt % 256]  = ar_addr_o;
        log_len[ar_cnt % 256]   = ar_len_o;
        log_size[ar_cnt % 256]  = ar_size_o;
        log_burst[ar_cnt % 256] = ar_burst_o;
        ar_cnt++;
      end
      @(posedge clk); #1;
      if (r_hs) begin
        if (rb_idx == int'(log_len[bq_rd % 256])) begin bq_rd++; rb_idx = 0; end
        else rb_idx++;
      end
      ar_ready = ar_toggle ? ~ar_ready : 1'b1;
      r_valid  = r_en && (bq_rd < ar_cnt);
      r_data   = log_addr[bq_rd % 256] + 32'(rb_idx * 4);
      r_resp   = 2'(rb_idx);
      r_last   = (rb_idx == int'(log_len[bq_rd % 256]));
    end
  end

  initial begin : rsp_monitor
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (rsp_valid_o) begin
        if (ex_rd == ex_wr) chk(1'b0, "R7", "unexpected beat", rsp_data_o, 0);
        else begin
          automatic int  bib   = ex_beat % 256;
          automatic bit  lastb = (ex_beat == ex_len[ex_rd % 64] - 1);
          automatic logic [31:0] ed = ex_addr[ex_rd % 64] + 32'(ex_beat * 4);
          chk(rsp_data_o == ed, "R7", "data", rsp_data_o, ed);
          chk(rsp_resp_o == 2'(bib), "R7", "resp", rsp_resp_o, bib % 4);
          chk(rsp_last_o == (lastb || bib == 255), "R7", "burst end", rsp_last_o, lastb || bib == 255);
          chk(req_done_o == lastb, "R9", "done on final beat", req_done_o, lastb);
          if (lastb) begin ex_rd++; ex_beat = 0; end
          else ex_beat++;
        end
      end else if (req_done_o) chk(1'b0, "R9", "done without beat", 1, 0);
      if (req_done_o) done_cnt++;
    end
  end

  task automatic send_req(input logic [31:0] a, input logic [15:0] l);
    req_addr = a; req_len = l; req_valid = 1'b1;
    do @(negedge clk); while (!req_ready_o);
    if (l != 0) begin
      ex_addr[ex_wr % 64] = a; ex_len[ex_wr % 64] = l; ex_wr++;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int n);
    while (done_cnt < n) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(req_ready_o == 1'b1, "R1", "ready after reset", req_ready_o, 1);
    chk(ar_valid_o == 1'b0, "R1", "ar_valid after reset", ar_valid_o, 0);
    chk(rsp_valid_o == 1'b0, "R1", "rsp_valid after reset", rsp_valid_o, 0);
    @(posedge clk); #1;
  endtask

  task automatic t_single;
    int a0 = ar_cnt, d0 = done_cnt;
    r_en = 1'b1;
    send_req(32'h1000, 16'd5);
    wait_done(d0 + 1);
    chk(ar_cnt == a0 + 1, "R4", "single burst count", ar_cnt - a0, 1);
    chk(log_addr[a0] == 32'h1000, "R4", "single addr", log_addr[a0], 32'h1000);
    chk(log_len[a0] == 8'd4, "R4", "single len", log_len[a0], 4);
    chk(log_size[a0] == 3'd2, "R5", "size", log_size[a0], 2);
    chk(log_burst[a0] == 2'b01, "R5", "burst type", log_burst[a0], 1);
  endtask

  task automatic t_split;
    int a0 = ar_cnt, d0 = done_cnt;
    ar_toggle = 1'b1;
    send_req(32'h2000, 16'd600);
    wait_done(d0 + 1);
    ar_toggle = 1'b0;
    chk(ar_cnt == a0 + 3, "R4", "split burst count", ar_cnt - a0, 3);
    chk(log_addr[a0] == 32'h2000, "R4", "burst0 addr", log_addr[a0], 32'h2000);
    chk(log_addr[a0+1] == 32'h2400, "R4", "burst1 addr", log_addr[a0+1], 32'h2400);
    chk(log_addr[a0+2] == 32'h2800, "R4", "burst2 addr", log_addr[a0+2], 32'h2800);
    chk(log_len[a0] == 8'd255, "R4", "burst0 len", log_len[a0], 255);
    chk(log_len[a0+1] == 8'd255, "R4", "burst1 len", log_len[a0+1], 255);
    chk(log_len[a0+2] == 8'd87, "R4", "burst2 len", log_len[a0+2], 87);
    chk(done_cnt == d0 + 1, "R9", "one done for split request", done_cnt - d0, 1);
  endtask

  task automatic t_capture;
    int a0 = ar_cnt, d0 = done_cnt;
    send_req(32'h3000, 16'd3);
    req_addr = 32'hdead0000; req_len = 16'd99;
    wait_done(d0 + 1);
    chk(log_addr[a0] == 32'h3000, "R3", "captured addr", log_addr[a0], 32'h3000);
    chk(log_len[a0] == 8'd2, "R3", "captured len", log_len[a0], 2);
  endtask

  task automatic t_outstanding;
    int a0, d0 = done_cnt;
    r_en = 1'b0;
    a0 = ar_cnt;
    send_req(32'h5000, 16'd0);
    repeat (8) @(negedge clk);
    chk(ar_cnt == a0, "R10", "no burst for zero length", ar_cnt - a0, 0);
    chk(req_ready_o == 1'b1, "R10", "ready after zero length", req_ready_o, 1);
    @(posedge clk); #1;
    for (int i = 0; i < 3; i++) send_req(32'h4000 + 32'(i * 64), 16'd2);
    @(negedge clk);
    chk(req_ready_o == 1'b1, "R10", "zero length not counted", req_ready_o, 1);
    @(posedge clk); #1;
    send_req(32'h40c0, 16'd2);
    @(negedge clk);
    chk(req_ready_o == 1'b0, "R2", "ready low at limit", req_ready_o, 0);
    @(posedge clk); #1;
    req_addr = 32'h4100; req_len = 16'd2; req_valid = 1'b1;
    repeat (14) @(negedge clk);
    chk(ar_cnt == a0 + 4, "R2", "fifth request held off", ar_cnt - a0, 4);
    chk(req_ready_o == 1'b0, "R2", "ready still low", req_ready_o, 0);
    @(posedge clk); #1;
    r_en = 1'b1;
    do @(negedge clk); while (!req_done_o);
    @(negedge clk);
    chk(req_ready_o == 1'b1, "R2", "ready cycle after done", req_ready_o, 1);
    ex_addr[ex_wr % 64] = 32'h4100; ex_len[ex_wr % 64] = 2; ex_wr++;
    @(posedge clk); #1;
    req_valid = 1'b0;
    wait_done(d0 + 5);
    chk(log_addr[a0+4] == 32'h4100, "R9", "fifth request issued last", log_addr[a0+4], 32'h4100);
  endtask

  task automatic t_backpressure;
    int d0 = done_cnt;
    rsp_dready = 1'b0;
    send_req(32'h6000, 16'd4);
    repeat (6) @(negedge clk);
    chk(r_valid == 1'b1, "R8", "model presenting beat", r_valid, 1);
    chk(r_ready_o == 1'b0, "R8", "r_ready follows dready low", r_ready_o, 0);
    chk(rsp_valid_o == 1'b0, "R8", "no beat while stalled", rsp_valid_o, 0);
    @(posedge clk); #1;
    for (int i = 0; i < 6; i++) begin
      rsp_dready = i[0];
      @(negedge clk);
      chk(r_ready_o == rsp_dready, "R8", "r_ready tracks dready", r_ready_o, rsp_dready);
      @(posedge clk); #1;
    end
    rsp_dready = 1'b1;
    wait_done(d0 + 1);
    chk(ex_rd == ex_wr, "R7", "all beats delivered", ex_rd, ex_wr);
  endtask

  initial begin : watchdog
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_single();
    t_split();
    t_capture();
    t_outstanding();
    t_backpressure();
    repeat (4) @(posedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule